// File: doc/BRIEF.md
# Bridge Type-1 Configuration Header Registers

This block stores the fixed 64-byte configuration header of a PCI-to-PCI bridge. Software reaches it through a plain configuration access port. The port carries a dword index, four byte enables, write data and a write strobe. Read data is driven combinationally from the dword index. Each dword is a cell with its own per-bit write mask and reset pattern. Identity, class, header type and status-capability bits are cells with no writable bits, so they always read their fixed values.

Two event outputs feed the rest of the bridge:

- **Window strobe.** It pulses for one cycle after any write that touches a byte involved in address forwarding. The logic that rebuilds the I/O and memory windows uses this strobe.
- **Secondary-bus reset pulse.** It lasts one cycle and fires only when the bus-reset control bit goes from 0 to 1.

Reset behaviour of the base/limit fields is chosen at build time. Either every window reads as zero, or the forwarding-disable preset fills the bases with ones and the limits with zeros, so that every window is empty.

Because this is a register port and not a data stream, it has no valid/ready handshake. A write is accepted in every cycle in which the strobe is high. A read is answered in the same cycle.

Top module: `cfg1_hdr`

## Requirements
- R1: After reset, the bus-number dword (index 6: primary, secondary, subordinate bus and secondary latency timer) and the bridge-control half of dword 15 (bits 31:16) read zero.
- R2: With DIS_FWD=0, the writable base/limit bits reset to zero. With DIS_FWD=1, the writable base bits reset to ones, the writable limit bits reset to zero, and the upper registers (dwords 10, 11, 12) reset to zero.
- R3: Each byte enable cfg_be_i[b] gates byte b (bits 8b+7:8b) independently. Only bits in a register's write mask change: command bits 0,1,2,6,8; I/O base/limit bits 7:4 of bytes 0 and 1 of dword 7; memory and prefetchable base/limit bits 15:4 of each half of dwords 8 and 9; bridge-control bits 11:0 (dword 15 bits 27:16).
- R4: The low nibble of the I/O base and limit bytes reads 1 when IO32=1. The low nibble of the prefetchable base and limit reads 1 when PREF64=1. Writes never change these nibbles.
- R5: Dword 0 reads {DEV_ID, VEN_ID}. Dword 2 reads {24'h060400, REV_ID}. Dword 3 bits 23:16 read {MULTI_FN, 7'h01}. All three ignore writes.
- R6: The primary status (dword 1 bits 31:16) and the secondary status (dword 7 bits 31:16) both read 16'h00A0: 66 MHz capable (bit 5) and fast back-to-back capable (bit 7). These bits are read-only.
- R7: A write whose enabled bytes include any byte address among 4–5, 0x1C–0x1D, 0x20–0x33 or 0x3E–0x3F raises remap_o for exactly the one cycle after the write edge.
- R8: A write whose enabled bytes all lie outside those ranges, or that has no byte enabled, leaves remap_o low.
- R9: sec_rst_o pulses high for one cycle, two clock edges after the write that changes bridge-control bit 6 (dword 15 bit 22) from 0 to 1. Rewriting 1 while the bit is already 1, or clearing the bit, gives no pulse.
- R10: When PREF64=1 and IO32=1, dwords 10, 11 and 12 are fully writable 32-bit registers.
- R11: Dwords with no implemented field (for example 4, 5, 13 and 14) read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Write strobe, one write per high cycle |
| cfg_addr_i | input | ADDR_W | Dword index into the header |
| cfg_be_i | input | 4 | Byte enables for the write |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data for cfg_addr_i, combinational |
| remap_o | output | 1 | One-cycle window re-evaluation strobe |
| sec_rst_o | output | 1 | One-cycle secondary bus reset request |

## Verification
The bench probes the edges of the strobe ranges: the status half of dword 1, the secondary-status half of dword 7, the interrupt bytes next to bridge control, and writes with no byte enabled. A decoder that worked per dword would pulse remap_o on each of these. Fixed nibbles, status bits and identity dwords are written with all ones, which catches a missing write mask. The bus-reset bit is written to 1 twice in a row and then cleared; a level-based or toggle-based detector would pulse a second time. A second instance built with the forwarding-disable preset checks the alternate reset pattern.

// File: rtl/cfg1_pkg.sv
package cfg1_pkg;

  localparam int DW_CNT   = 16;
  localparam int BCTL_DW  = 15;
  localparam int BUSRST_B = 22;
  localparam logic [23:0] CLASS_P2P = 24'h060400;
  localparam logic [15:0] STAT_CAPS = 16'h00A0;

  function automatic logic [31:0] dw_wmask(input int idx, input bit io32, input bit pref64);
    logic [31:0] m;
    case (idx)
      1:       m = 32'h0000_0147;
      6:       m = 32'hFFFF_FFFF;
      7:       m = 32'h0000_F0F0;
      8, 9:    m = 32'hFFF0_FFF0;
      10, 11:  m = pref64 ? 32'hFFFF_FFFF : 32'h0;
      12:      m = io32 ? 32'hFFFF_FFFF : 32'h0;
      BCTL_DW: m = 32'h0FFF_0000;
      default: m = 32'h0;
    endcase
    return m;
  endfunction

  function automatic logic [31:0] dw_reset(input int idx, input bit io32, input bit pref64,
                                           input bit mfn, input bit dis,
                                           input logic [15:0] vid, input logic [15:0] did,
                                           input logic [7:0] rev);
    logic [3:0]  iot;
    logic [3:0]  pft;
    logic [3:0]  iob;
    logic [11:0] mb;
    logic [31:0] v;
    iot = io32 ? 4'h1 : 4'h0;
    pft = pref64 ? 4'h1 : 4'h0;
    iob = dis ? 4'hF : 4'h0;
    mb  = dis ? 12'hFFF : 12'h000;
    case (idx)
      0:       v = {did, vid};
      1:       v = {STAT_CAPS, 16'h0000};
      2:       v = {CLASS_P2P, rev};
      3:       v = {8'h00, mfn, 7'h01, 16'h0000};
      7:       v = {STAT_CAPS, 4'h0, iot, iob, iot};
      8:       v = {16'h0000, mb, 4'h0};
      9:       v = {12'h000, pft, mb, pft};
      default: v = 32'h0;
    endcase
    return v;
  endfunction

  function automatic logic remap_byte(input int ba);
    return (ba >= 4 && ba <= 5) || (ba >= 'h1C && ba <= 'h1D) ||
           (ba >= 'h20 && ba <= 'h33) || (ba >= 'h3E && ba <= 'h3F);
  endfunction

endpackage

// File: rtl/cfg1_dword.sv
module cfg1_dword #(
  parameter logic [31:0] WMASK  = 32'h0,
  parameter logic [31:0] RSTVAL = 32'h0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] q_o
);
  if (WMASK == 32'h0) begin : g_const
    assign q_o = RSTVAL;
  end else begin : g_store
    logic [31:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= RSTVAL;
      end else if (we_i) begin
        for (int b = 0; b < 4; b++) begin
          if (be_i[b])
            q[8*b +: 8] <= (q[8*b +: 8] & ~WMASK[8*b +: 8]) |
                           (wdata_i[8*b +: 8] & WMASK[8*b +: 8]);
        end
      end
    end
    assign q_o = q;
  end
endmodule

// File: rtl/cfg1_events.sv
module cfg1_events #(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic              busrst_bit_i,
  output logic              remap_o,
  output logic              sec_rst_o
);
  import cfg1_pkg::*;

  logic [3:0] hit;
  logic       remap_q;
  logic       busrst_d;
  logic       sec_q;

  for (genvar b = 0; b < 4; b++) begin : g_hit
    assign hit[b] = be_i[b] && remap_byte(int'(addr_i) * 4 + b);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remap_q  <= 1'b0;
      busrst_d <= 1'b0;
      sec_q    <= 1'b0;
    end else begin
      remap_q  <= wr_i && (|hit);
      busrst_d <= busrst_bit_i;
      sec_q    <= busrst_bit_i && !busrst_d;
    end
  end

  assign remap_o   = remap_q;
  assign sec_rst_o = sec_q;
endmodule

// File: rtl/cfg1_hdr.sv
module cfg1_hdr #(
  parameter int          ADDR_W   = 6,
  parameter bit          IO32     = 1'b1,
  parameter bit          PREF64   = 1'b1,
  parameter bit          MULTI_FN = 1'b0,
  parameter bit          DIS_FWD  = 1'b0,
  parameter logic [15:0] VEN_ID   = 16'hABCD,
  parameter logic [15:0] DEV_ID   = 16'h0001,
  parameter logic [7:0]  REV_ID   = 8'h00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [3:0]        cfg_be_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  output logic              remap_o,
  output logic              sec_rst_o
);
  import cfg1_pkg::*;

  logic [31:0] dw [DW_CNT];

  for (genvar i = 0; i < DW_CNT; i++) begin : g_dw
    cfg1_dword #(
      .WMASK (dw_wmask(i, IO32, PREF64)),
      .RSTVAL(dw_reset(i, IO32, PREF64, MULTI_FN, DIS_FWD, VEN_ID, DEV_ID, REV_ID))
    ) u_dw (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (cfg_wr_i && (int'(cfg_addr_i) == i)),
      .be_i   (cfg_be_i),
      .wdata_i(cfg_wdata_i),
      .q_o    (dw[i])
    );
  end

  always_comb begin
    cfg_rdata_o = 32'h0;
    for (int i = 0; i < DW_CNT; i++)
      if (int'(cfg_addr_i) == i) cfg_rdata_o = dw[i];
  end

  cfg1_events #(.ADDR_W(ADDR_W)) u_ev (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (cfg_wr_i),
    .addr_i      (cfg_addr_i),
    .be_i        (cfg_be_i),
    .busrst_bit_i(dw[BCTL_DW][BUSRST_B]),
    .remap_o     (remap_o),
    .sec_rst_o   (sec_rst_o)
  );
endmodule

// File: rtl/cfg1_hdr_chk.sv
module cfg1_hdr_chk #(
  parameter int ADDR_W = 6,
  parameter bit IO32   = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_wr_i,
  input logic [ADDR_W-1:0] cfg_addr_i,
  input logic [31:0]       cfg_rdata_o,
  input logic              remap_o,
  input logic              sec_rst_o
);
  localparam logic [3:0] IOT = IO32 ? 4'h1 : 4'h0;

  a_r7_remap_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remap_o |-> $past(cfg_wr_i));

  a_r9_secrst_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_rst_o |=> !sec_rst_o);

  a_r9_secrst_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_rst_o |-> $past(cfg_wr_i, 2));

  a_r5_class_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(cfg_addr_i) == 2) |-> (cfg_rdata_o[31:8] == 24'h060400));

  a_r6_status_caps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(cfg_addr_i) == 1 || int'(cfg_addr_i) == 7) |-> (cfg_rdata_o[21] && cfg_rdata_o[23]));

  a_r4_io_type: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(cfg_addr_i) == 7) |-> (cfg_rdata_o[3:0] == IOT && cfg_rdata_o[11:8] == IOT));

  a_r11_hole_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(cfg_addr_i) == 4 || int'(cfg_addr_i) == 13) |-> (cfg_rdata_o == 32'h0));
endmodule

bind cfg1_hdr cfg1_hdr_chk #(.ADDR_W(ADDR_W), .IO32(IO32)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_wr_i   (cfg_wr_i),
  .cfg_addr_i (cfg_addr_i),
  .cfg_rdata_o(cfg_rdata_o),
  .remap_o    (remap_o),
  .sec_rst_o  (sec_rst_o)
);

// File: tb/cfg1_hdr_tb.sv
module cfg1_hdr_tb;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [3:0]    be = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata, rdata_dis;
  logic          remap, sec_rst, remap_dis, sec_rst_dis;
  logic          last_remap;
  int            n_chk = 0;
  int            n_bad = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  cfg1_hdr #(.ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(wr), .cfg_addr_i(addr), .cfg_be_i(be),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .remap_o(remap), .sec_rst_o(sec_rst));

  cfg1_hdr #(.ADDR_W(AW), .DIS_FWD(1'b1)) u_dut_dis (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(wr), .cfg_addr_i(addr), .cfg_be_i(be),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata_dis), .remap_o(remap_dis), .sec_rst_o(sec_rst_dis));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_dw(input int a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = AW'(a); be = b; wdata = d;
    @(negedge clk);
    wr = 1'b0; be = '0;
    last_remap = remap;
  endtask

  task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
    @(negedge clk);
    addr = AW'(a);
    #1 check(req, rdata, exp);
  endtask

  task automatic rd_chk_dis(input string req, input int a, input logic [31:0] exp);
    @(negedge clk);
    addr = AW'(a);
    #1 check(req, rdata_dis, exp);
  endtask

  task automatic t_reset;
    check("R1 remap idle", {31'b0, remap}, 32'h0);
    check("R1 secrst idle", {31'b0, sec_rst}, 32'h0);
    rd_chk("R1 bus numbers", 6, 32'h0);
    rd_chk("R1 bridge control", 15, 32'h0);
    rd_chk("R2 io base/limit", 7, 32'h00A0_0101);
    rd_chk("R2 mem base/limit", 8, 32'h0);
    rd_chk("R2 pref base/limit", 9, 32'h0001_0001);
    rd_chk("R2 io upper", 12, 32'h0);
    rd_chk_dis("R2 dis io", 7, 32'h00A0_01F1);
    rd_chk_dis("R2 dis mem", 8, 32'h0000_FFF0);
    rd_chk_dis("R2 dis pref", 9, 32'h0001_FFF1);
    rd_chk_dis("R2 dis pref upper base", 10, 32'h0);
    rd_chk_dis("R2 dis pref upper limit", 11, 32'h0);
  endtask

  task automatic t_identity;
    wr_dw(0, 4'hF, 32'hFFFF_FFFF);
    check("R8 no strobe id write", {31'b0, last_remap}, 32'h0);
    wr_dw(2, 4'hF, 32'hFFFF_FFFF);
    wr_dw(3, 4'hF, 32'hFFFF_FFFF);
    rd_chk("R5 ids", 0, 32'h0001_ABCD);
    rd_chk("R5 class", 2, 32'h0604_0000);
    rd_chk("R5 header type", 3, 32'h0001_0000);
  endtask

  task automatic t_bus;
    wr_dw(6, 4'hF, 32'h2005_0301);
    check("R8 no strobe bus write", {31'b0, last_remap}, 32'h0);
    rd_chk("R3 bus write", 6, 32'h2005_0301);
    wr_dw(6, 4'b0010, 32'hAAAA_AAAA);
    rd_chk("R3 single byte enable", 6, 32'h2005_AA01);
  endtask

  task automatic t_masks;
    wr_dw(8, 4'hF, 32'hFFFF_FFFF);
    check("R7 strobe mem", {31'b0, last_remap}, 32'h1);
    rd_chk("R3 mem mask", 8, 32'hFFF0_FFF0);
    wr_dw(7, 4'hF, 32'hFFFF_FFFF);
    check("R7 strobe io", {31'b0, last_remap}, 32'h1);
    rd_chk("R4 R6 io nibble and sec status", 7, 32'h00A0_F1F1);
    wr_dw(9, 4'hF, 32'hFFFF_FFFF);
    rd_chk("R4 pref nibble", 9, 32'hFFF1_FFF1);
    wr_dw(1, 4'hF, 32'hFFFF_FFFF);
    check("R7 strobe command", {31'b0, last_remap}, 32'h1);
    rd_chk("R3 R6 command mask and status", 1, 32'h00A0_0147);
  endtask

  task automatic t_remap;
    wr_dw(7, 4'b1100, 32'hFFFF_FFFF);
    check("R8 sec status bytes", {31'b0, last_remap}, 32'h0);
    wr_dw(1, 4'b1100, 32'hFFFF_FFFF);
    check("R8 status bytes", {31'b0, last_remap}, 32'h0);
    wr_dw(15, 4'b0011, 32'hFFFF_FFFF);
    check("R8 interrupt bytes", {31'b0, last_remap}, 32'h0);
    wr_dw(8, 4'b0000, 32'h1234_5678);
    check("R8 no byte enabled", {31'b0, last_remap}, 32'h0);
    wr_dw(15, 4'b0100, 32'h0001_0000);
    check("R7 bridge control byte", {31'b0, last_remap}, 32'h1);
    wr_dw(12, 4'b0001, 32'h0000_0055);
    check("R7 io upper byte", {31'b0, last_remap}, 32'h1);
    @(negedge clk);
    check("R7 one cycle", {31'b0, remap}, 32'h0);
    wr_dw(13, 4'hF, 32'hFFFF_FFFF);
    check("R8 hole write", {31'b0, last_remap}, 32'h0);
    rd_chk("R11 hole 13", 13, 32'h0);
    wr_dw(4, 4'hF, 32'hFFFF_FFFF);
    rd_chk("R11 hole 4", 4, 32'h0);
    rd_chk("R3 bctl after byte write", 15, 32'h0001_0000);
  endtask

  task automatic t_upper;
    wr_dw(10, 4'hF, 32'hDEAD_BEEF);
    check("R7 strobe pref upper", {31'b0, last_remap}, 32'h1);
    wr_dw(11, 4'hF, 32'hCAFE_F00D);
    wr_dw(12, 4'hF, 32'h1234_5678);
    rd_chk("R10 pref upper base", 10, 32'hDEAD_BEEF);
    rd_chk("R10 pref upper limit", 11, 32'hCAFE_F00D);
    rd_chk("R10 io upper", 12, 32'h1234_5678);
  endtask

  task automatic pulse_watch(input string req, input logic exp_pulse);
    check({req, " write cycle"}, {31'b0, sec_rst}, 32'h0);
    @(negedge clk);
    check({req, " pulse cycle"}, {31'b0, sec_rst}, {31'b0, exp_pulse});
    @(negedge clk);
    check({req, " after"}, {31'b0, sec_rst}, 32'h0);
  endtask

  task automatic t_secrst;
    wr_dw(15, 4'b0100, 32'h0040_0000);
    pulse_watch("R9 rise", 1'b1);
    rd_chk("R9 bit held", 15, 32'h0040_0000);
    wr_dw(15, 4'b0100, 32'h0040_0000);
    pulse_watch("R9 hold no retrigger", 1'b0);
    wr_dw(15, 4'b0100, 32'h0000_0000);
    pulse_watch("R9 clear no pulse", 1'b0);
    wr_dw(15, 4'b0100, 32'h0040_0000);
    pulse_watch("R9 second rise", 1'b1);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_identity();
    t_bus();
    t_masks();
    t_remap();
    t_upper();
    t_secrst();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule